// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the RAS and CAS strobes of an asynchronous DRAM whenever the array needs refreshing and nobody else is allowed near it. After reset it waits out a power-up pause, counted in external time ticks. It then issues a fixed number of CAS-before-RAS (CBR) warm-up cycles and raises an init-done flag that lets the access controller start. From then on a tick-driven interval counter schedules one CBR cycle per interval.

Refresh cycles are negotiated with the access controller through a request/grant pair. When the controller cannot release the bus, missed intervals are counted, up to a ceiling. Once the grant arrives, every postponed refresh is issued back to back under a single grant. When the count reaches the ceiling, an urgent flag tells the controller to yield at once. The grant must stay high for as long as the request does.

A low-power request moves the device into self refresh. The whole array is refreshed with distributed CBR cycles first. RAS is then held low for at least a minimum number of ticks, so that it never stops inside the forbidden band between a normal cycle and self refresh. On exit, a long precharge is enforced and the whole array is refreshed again before the bus is handed back.

Top module: `dram_refresh_seq`

## Requirements
- R1: Out of reset ras_n_o and cas_n_o are high, and init_done_o, busy_o and ref_req_o are low. No strobe moves until PAUSE_TICKS tick pulses (tick_i high for one clock each) have been counted.
- R2: After the pause exactly INIT_CBR CBR cycles are issued without raising ref_req_o. init_done_o then rises and stays high until reset.
- R3: Every normal CBR cycle drops CAS at least CSR_CYC clocks before RAS falls. RAS stays low for exactly CHR_CYC+RASL_CYC clocks, with CAS held low for the first CHR_CYC of them. Both strobes are then high for at least RP_CYC clocks.
- R4: RAS never falls while CAS is high; every cycle the block drives is CAS-before-RAS.
- R5: Once init_done_o is high, every TICKS_PER_REF tick pulses add one pending refresh. ref_req_o rises when a refresh is pending, and fewer than TICKS_PER_REF ticks leave it low.
- R6: The pending count saturates at MAX_PEND. ref_urgent_o is high exactly while the count equals MAX_PEND, so a grant after any longer stall yields exactly MAX_PEND cycles.
- R7: Once granted, all pending refreshes are issued back to back with ref_req_o held high. ref_req_o and busy_o fall only after the last cycle's precharge, with both strobes high.
- R8: After initialization the strobes are driven low only while ref_gnt_i is high.
- R9: With lp_req_i high in idle, the block requests the bus and issues ROWS CBR cycles. It then enters self refresh by holding both strobes low.
- R10: In self refresh RAS stays low for at least SR_MIN_TICKS ticks even if lp_req_i is already low, and for as long as lp_req_i stays high.
- R11: On leaving self refresh both strobes stay high for at least RPS_CYC clocks. ROWS more CBR cycles follow, then the pending count and interval are cleared and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock time-base pulse |
| lp_req_i | input | 1 | Low-power (self refresh) request |
| ref_gnt_i | input | 1 | Bus grant from the access controller, held while ref_req_o is high |
| ref_req_o | output | 1 | Bus request for refresh |
| ref_urgent_o | output | 1 | Pending refresh count at its ceiling |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| busy_o | output | 1 | Sequencer owns the strobes |
| init_done_o | output | 1 | Power-up sequence finished |

## Verification
The hardest state to reach is self refresh, and the exit from it, with lp_req_i already withdrawn. The entry only happens after a full array refresh under a held grant, and the minimum RAS-low time is measured in ticks rather than clocks. The stimulus raises the low-power request and keeps the tick pulses running through the whole sequence. It drops the request as soon as the monitor sees RAS stay low beyond a normal cycle width. A second run keeps the request high well past the minimum. Saturation of the pending count is reached by withholding the grant across more intervals than the ceiling and then granting once.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    SQ_PAUSE, SQ_INIT, SQ_IDLE, SQ_REQ, SQ_BURST, SQ_PRE_SR, SQ_SELF, SQ_POST_SR
  } seq_state_e;

  typedef enum logic [2:0] {
    CG_IDLE, CG_SETUP, CG_HOLD, CG_TAIL, CG_SELF, CG_PRECH
  } cyc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval
  import dram_ref_pkg::*;
#(
  parameter int TICKS_PER_REF = 16,
  parameter int MAX_PEND      = 8,
  localparam int IW = $clog2(TICKS_PER_REF + 1),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          dec_i,
  output logic [PW-1:0] pend_o,
  output logic          full_o
);

  localparam logic [IW-1:0] ILAST = IW'(TICKS_PER_REF - 1);
  localparam logic [PW-1:0] PMAX  = PW'(MAX_PEND);

  logic [IW-1:0] icnt_q;
  logic [PW-1:0] pend_q;
  logic          expire, inc, dec;

  assign expire = en_i && tick_i && (icnt_q == ILAST);
  assign inc    = expire && (pend_q != PMAX);
  assign dec    = dec_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      icnt_q <= '0;
      pend_q <= '0;
    end else begin
      if (en_i && tick_i) icnt_q <= expire ? '0 : icnt_q + IW'(1);
      pend_q <= pend_q + PW'(inc) - PW'(dec);
    end
  end

  assign pend_o = pend_q;
  assign full_o = (pend_q == PMAX);

  p_pend_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PMAX);

  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !dec_i && !clr_i |=> full_o);

endmodule

// File: rtl/dram_ref_cyc_gen.sv
module dram_ref_cyc_gen
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC  = 1,
  parameter int CHR_CYC  = 1,
  parameter int RASL_CYC = 3,
  parameter int RP_CYC   = 3,
  parameter int RPS_CYC  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic self_i,
  input  logic hold_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o,
  output logic idle_o
);

  localparam int MAXC = imax(imax(imax(CSR_CYC, CHR_CYC), imax(RASL_CYC, RP_CYC)), RPS_CYC);
  localparam int TW   = $clog2(MAXC + 1);

  cyc_state_e    st_q;
  logic [TW-1:0] tmr_q;
  logic          self_q;
  logic          tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CG_IDLE;
      tmr_q  <= '0;
      self_q <= 1'b0;
    end else begin
      unique case (st_q)
        CG_IDLE: if (start_i) begin
          st_q   <= CG_SETUP;
          tmr_q  <= TW'(CSR_CYC - 1);
          self_q <= self_i;
        end
        CG_SETUP: if (tmr_zero) begin
          st_q  <= CG_HOLD;
          tmr_q <= TW'(CHR_CYC - 1);
        end else tmr_q <= tmr_q - TW'(1);
        CG_HOLD: if (tmr_zero) begin
          if (self_q) st_q <= CG_SELF;
          else begin
            st_q  <= CG_TAIL;
            tmr_q <= TW'(RASL_CYC - 1);
          end
        end else tmr_q <= tmr_q - TW'(1);
        CG_TAIL: if (tmr_zero) begin
          st_q  <= CG_PRECH;
          tmr_q <= TW'(RP_CYC - 1);
        end else tmr_q <= tmr_q - TW'(1);
        CG_SELF: if (!hold_i) begin
          st_q  <= CG_PRECH;
          tmr_q <= TW'(RPS_CYC - 1);
        end
        CG_PRECH: if (tmr_zero) st_q <= CG_IDLE;
                  else tmr_q <= tmr_q - TW'(1);
        default: st_q <= CG_IDLE;
      endcase
    end
  end

  assign ras_n_o = !(st_q inside {CG_HOLD, CG_TAIL, CG_SELF});
  assign cas_n_o = !(st_q inside {CG_SETUP, CG_HOLD, CG_SELF});
  assign done_o  = (st_q == CG_PRECH) && tmr_zero;
  assign idle_o  = (st_q == CG_IDLE);

  p_cas_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !cas_n_o);

  p_cas_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !$past(cas_n_o));

  p_prech_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |=> ras_n_o && cas_n_o);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int ROWS          = 1024,
  parameter int INIT_CBR      = 8,
  parameter int TICKS_PER_REF = 16,
  parameter int PAUSE_TICKS   = 100,
  parameter int SR_MIN_TICKS  = 100,
  parameter int MAX_PEND      = 8,
  parameter int CSR_CYC       = 1,
  parameter int CHR_CYC       = 1,
  parameter int RASL_CYC      = 3,
  parameter int RP_CYC        = 3,
  parameter int RPS_CYC       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lp_req_i,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic init_done_o
);

  localparam int CW  = $clog2(imax(ROWS, INIT_CBR) + 1);
  localparam int TKW = $clog2(imax(PAUSE_TICKS, SR_MIN_TICKS) + 1);
  localparam int PW  = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0]  N_ROWS     = CW'(ROWS);
  localparam logic [CW-1:0]  N_INIT     = CW'(INIT_CBR);
  localparam logic [TKW-1:0] PAUSE_LAST = TKW'(PAUSE_TICKS - 1);
  localparam logic [TKW-1:0] SR_MIN     = TKW'(SR_MIN_TICKS);

  seq_state_e     st_q;
  logic [CW-1:0]  cyc_cnt_q;
  logic [TKW-1:0] tk_cnt_q;
  logic           inflight_q, lp_q, init_done_q;

  logic           cyc_start, cyc_self, cyc_hold, cyc_done, cyc_idle;
  logic           pend_dec, pend_clr, pend_full;
  logic [PW-1:0]  pend;
  logic           sr_min_met, run_done;
  logic [CW-1:0]  run_target;

  dram_ref_interval #(
    .TICKS_PER_REF (TICKS_PER_REF),
    .MAX_PEND      (MAX_PEND)
  ) i_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_q),
    .tick_i (tick_i),
    .clr_i  (pend_clr),
    .dec_i  (pend_dec),
    .pend_o (pend),
    .full_o (pend_full)
  );

  dram_ref_cyc_gen #(
    .CSR_CYC  (CSR_CYC),
    .CHR_CYC  (CHR_CYC),
    .RASL_CYC (RASL_CYC),
    .RP_CYC   (RP_CYC),
    .RPS_CYC  (RPS_CYC)
  ) i_cyc_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cyc_start),
    .self_i  (cyc_self),
    .hold_i  (cyc_hold),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .done_o  (cyc_done),
    .idle_o  (cyc_idle)
  );

  assign sr_min_met = (tk_cnt_q == SR_MIN);
  assign cyc_hold   = !(sr_min_met && !lp_req_i);
  assign cyc_self   = (st_q == SQ_SELF);
  assign run_target = (st_q == SQ_INIT) ? N_INIT : N_ROWS;
  assign run_done   = !inflight_q && (cyc_cnt_q == run_target);

  always_comb begin
    cyc_start = 1'b0;
    unique case (st_q)
      SQ_INIT, SQ_PRE_SR, SQ_POST_SR: cyc_start = !inflight_q && cyc_idle && (cyc_cnt_q != run_target);
      SQ_BURST:                       cyc_start = !inflight_q && cyc_idle && (pend != '0);
      SQ_SELF:                        cyc_start = !inflight_q && cyc_idle;
      default:                        cyc_start = 1'b0;
    endcase
  end

  assign pend_dec = cyc_done && (st_q == SQ_BURST);
  assign pend_clr = (st_q == SQ_POST_SR) && run_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_PAUSE;
      cyc_cnt_q   <= '0;
      tk_cnt_q    <= '0;
      inflight_q  <= 1'b0;
      lp_q        <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      if (cyc_start) inflight_q <= 1'b1;
      else if (cyc_done) inflight_q <= 1'b0;
      if (cyc_done && (st_q inside {SQ_INIT, SQ_PRE_SR, SQ_POST_SR}))
        cyc_cnt_q <= cyc_cnt_q + CW'(1);

      unique case (st_q)
        SQ_PAUSE: if (tick_i) begin
          if (tk_cnt_q == PAUSE_LAST) begin
            st_q     <= SQ_INIT;
            tk_cnt_q <= '0;
          end else tk_cnt_q <= tk_cnt_q + TKW'(1);
        end
        SQ_INIT: if (run_done) begin
          st_q        <= SQ_IDLE;
          cyc_cnt_q   <= '0;
          init_done_q <= 1'b1;
        end
        SQ_IDLE: begin
          if (lp_req_i) begin
            st_q <= SQ_REQ;
            lp_q <= 1'b1;
          end else if (pend != '0) begin
            st_q <= SQ_REQ;
            lp_q <= 1'b0;
          end
        end
        SQ_REQ: if (ref_gnt_i) st_q <= lp_q ? SQ_PRE_SR : SQ_BURST;
        SQ_BURST: if (!inflight_q && (pend == '0)) st_q <= SQ_IDLE;
        SQ_PRE_SR: if (run_done) begin
          st_q      <= SQ_SELF;
          cyc_cnt_q <= '0;
          tk_cnt_q  <= '0;
        end
        SQ_SELF: begin
          if (tick_i && !sr_min_met) tk_cnt_q <= tk_cnt_q + TKW'(1);
          if (cyc_done) st_q <= SQ_POST_SR;
        end
        SQ_POST_SR: if (run_done) begin
          st_q      <= SQ_IDLE;
          cyc_cnt_q <= '0;
          lp_q      <= 1'b0;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ref_req_o    = st_q inside {SQ_REQ, SQ_BURST, SQ_PRE_SR, SQ_SELF, SQ_POST_SR};
  assign busy_o       = st_q inside {SQ_INIT, SQ_BURST, SQ_PRE_SR, SQ_SELF, SQ_POST_SR};
  assign ref_urgent_o = pend_full;
  assign init_done_o  = init_done_q;

  p_quiet_pause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_PAUSE) |-> ras_n_o && cas_n_o);

  p_no_req_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !ref_req_o);

  p_init_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_release_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_req_o) |-> ras_n_o && cas_n_o);

  p_strobe_gnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o && (!ras_n_o || !cas_n_o) |-> ref_gnt_i);

  p_sr_min_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_SELF) && ($past(st_q) == SQ_SELF) && !$past(ras_n_o) && !sr_min_met
      |-> !ras_n_o);

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 10;
  localparam int ROWS       = 16;
  localparam int INIT_CBR   = 8;
  localparam int TPR        = 4;
  localparam int PAUSE      = 10;
  localparam int SR_MIN     = 20;
  localparam int MAX_PEND   = 8;
  localparam int CSR_CYC    = 1;
  localparam int CHR_CYC    = 1;
  localparam int RASL_CYC   = 3;
  localparam int RP_CYC     = 3;
  localparam int RPS_CYC    = 6;
  localparam int LONG_LOW   = 40;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, lp_req = 1'b0, gnt_en = 1'b1;
  logic ref_gnt, ref_req, urgent, ras_n, cas_n, busy, init_done;

  assign ref_gnt = gnt_en & ref_req;

  dram_refresh_seq #(
    .ROWS(ROWS), .INIT_CBR(INIT_CBR), .TICKS_PER_REF(TPR), .PAUSE_TICKS(PAUSE),
    .SR_MIN_TICKS(SR_MIN), .MAX_PEND(MAX_PEND), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
    .RASL_CYC(RASL_CYC), .RP_CYC(RP_CYC), .RPS_CYC(RPS_CYC)
  ) i_dram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lp_req_i(lp_req), .ref_gnt_i(ref_gnt),
    .ref_req_o(ref_req), .ref_urgent_o(urgent), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .busy_o(busy), .init_done_o(init_done)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // strobe monitor
  int cbr_cnt = 0, sr_cnt = 0, sr_width = 0, cbr_at_sr = 0;
  int order_err = 0, lead_err = 0, width_err = 0, gnt_err = 0, rps_err = 0, req_pre_init = 0;
  int ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
  bit prev_ras = 1'b1, after_sr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_req && !init_done) req_pre_init++;
      if (prev_ras && !ras_n) begin
        if (cas_n) order_err++;
        if (cas_low_run < CSR_CYC) lead_err++;
        if (init_done && !ref_gnt) gnt_err++;
        if (after_sr && ras_high_run < RPS_CYC) rps_err++;
        if (ras_high_run < RP_CYC) width_err++;
        after_sr = 1'b0;
      end
      if (!prev_ras && ras_n) begin
        if (ras_low_run > LONG_LOW) begin
          sr_cnt++; sr_width = ras_low_run; cbr_at_sr = cbr_cnt; after_sr = 1'b1;
        end else begin
          cbr_cnt++;
          if (ras_low_run != CHR_CYC + RASL_CYC) width_err++;
        end
        ras_low_run = 0;
        ras_high_run = 0;
      end
      if (!ras_n) ras_low_run++; else ras_high_run++;
      if (!cas_n) cas_low_run++; else cas_low_run = 0;
      prev_ras = ras_n;
    end
  end

  task automatic nclk();
    @(negedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      nclk(); tick = 1'b1;
      nclk(); tick = 1'b0;
      for (int j = 0; j < TICK_GAP - 2; j++) nclk();
    end
  endtask

  task automatic wait_idle(input string req);
    int lim = 0;
    do begin nclk(); lim++; end while ((busy || ref_req) && lim < 5000);
    check(lim < 5000, req, lim, 5000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) nclk();
    rst_n = 1'b1;
    nclk();
    check(ras_n && cas_n, "R1 strobes high after reset", {ras_n, cas_n}, 3);
    check(!init_done && !busy && !ref_req, "R1 flags low after reset",
          {init_done, busy, ref_req}, 0);
  endtask

  task automatic t_init();
    give_ticks(PAUSE - 1);
    for (int i = 0; i < 20; i++) nclk();
    check(cbr_cnt == 0 && ras_n && cas_n, "R1 quiet during pause", cbr_cnt, 0);
    check(!init_done, "R1 init_done low during pause", init_done, 0);
    give_ticks(1);
    for (int i = 0; i < 300 && !init_done; i++) nclk();
    check(init_done, "R2 init_done rises", init_done, 1);
    check(cbr_cnt == INIT_CBR, "R2 warm-up cycle count", cbr_cnt, INIT_CBR);
    check(req_pre_init == 0, "R2 no request during init", req_pre_init, 0);
    check(!busy, "R2 busy low after init", busy, 0);
  endtask

  task automatic t_interval();
    int base = cbr_cnt;
    give_ticks(TPR - 1);
    for (int i = 0; i < 5; i++) nclk();
    check(!ref_req && cbr_cnt == base, "R5 no request before interval", ref_req, 0);
    give_ticks(1);
    wait_idle("R5 idle after interval refresh");
    check(cbr_cnt - base == 1, "R5 one cycle per interval", cbr_cnt - base, 1);
    base = cbr_cnt;
    give_ticks(3 * TPR);
    wait_idle("R5 idle after three intervals");
    check(cbr_cnt - base == 3, "R5 three intervals three cycles", cbr_cnt - base, 3);
    check(init_done, "R2 init_done stays high", init_done, 1);
  endtask

  task automatic t_deferred();
    int base = cbr_cnt;
    gnt_en = 1'b0;
    give_ticks(3 * TPR);
    check(ref_req, "R5 request raised while pending", ref_req, 1);
    check(cbr_cnt == base, "R8 no cycle without grant", cbr_cnt - base, 0);
    check(!urgent, "R6 urgent low below ceiling", urgent, 0);
    gnt_en = 1'b1;
    wait_idle("R7 burst completes");
    check(cbr_cnt - base == 3, "R7 postponed burst count", cbr_cnt - base, 3);
    check(!ref_req && ras_n && cas_n, "R7 bus released idle", ref_req, 0);
  endtask

  task automatic t_saturate();
    int base = cbr_cnt;
    gnt_en = 1'b0;
    give_ticks((MAX_PEND + 3) * TPR);
    check(urgent, "R6 urgent at ceiling", urgent, 1);
    check(cbr_cnt == base, "R8 stalled without grant", cbr_cnt - base, 0);
    gnt_en = 1'b1;
    wait_idle("R6 saturated burst completes");
    check(cbr_cnt - base == MAX_PEND, "R6 saturated burst count", cbr_cnt - base, MAX_PEND);
    check(!urgent, "R6 urgent clears after burst", urgent, 0);
  endtask

  task automatic run_self(input int hold_ticks);
    int base = cbr_cnt;
    int sr_base = sr_cnt;
    int lim = 0, gap = 0, sr_ticks = 0;
    bit in_sr = 1'b0;
    int exp_min = ((hold_ticks > SR_MIN) ? hold_ticks : SR_MIN) - 1;
    lp_req = 1'b1;
    while (lim < 20000 && !(sr_cnt > sr_base && !busy && !ref_req)) begin
      nclk(); lim++;
      tick = (gap == 0);
      gap = (gap == TICK_GAP - 1) ? 0 : gap + 1;
      if (ras_low_run > LONG_LOW) in_sr = 1'b1;
      if (in_sr && tick && sr_cnt == sr_base) sr_ticks++;
      if (in_sr && sr_ticks >= hold_ticks) lp_req = 1'b0;
    end
    tick = 1'b0;
    lp_req = 1'b0;
    check(lim < 20000, "R9 self refresh sequence finishes", lim, 20000);
    check(sr_cnt - sr_base == 1, "R9 one self refresh entry", sr_cnt - sr_base, 1);
    check(cbr_at_sr - base == ROWS, "R9 full refresh before entry", cbr_at_sr - base, ROWS);
    check(sr_width >= exp_min * TICK_GAP, "R10 self refresh RAS low width", sr_width,
          exp_min * TICK_GAP);
    check(cbr_cnt - cbr_at_sr == ROWS, "R11 full refresh after exit", cbr_cnt - cbr_at_sr, ROWS);
    check(rps_err == 0, "R11 long precharge after exit", rps_err, 0);
    for (int i = 0; i < 50; i++) nclk();
    check(!ref_req && ras_n && cas_n, "R11 pending cleared and bus released", ref_req, 0);
  endtask

  initial begin
    t_reset();
    t_init();
    t_interval();
    t_deferred();
    t_saturate();
    run_self(0);
    run_self(2 * SR_MIN);
    check(order_err == 0, "R4 RAS fell with CAS high", order_err, 0);
    check(lead_err == 0, "R3 CAS lead before RAS", lead_err, 0);
    check(width_err == 0, "R3 RAS low width or precharge", width_err, 0);
    check(gnt_err == 0, "R8 strobe without grant", gnt_err, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule